// File: doc/BRIEF.md
# Floating-Point Condition Compare Unit

This block compares two floating-point operands and produces condition-code bits for a floating-point pipeline. A 2-bit format select chooses single precision (one 32-bit value in the low word), double precision (one 64-bit value), or paired-single (two independent 32-bit lanes packed in each 64-bit bus). A 4-bit predicate select picks one of sixteen predicates. Bits 2:0 of the predicate say which relations make it true: unordered, equal or less-than. Bit 3 makes a quiet NaN raise the invalid-operation flag.

A magnitude mode clears every sign bit before the comparison, so the unit then compares absolute values. The unit also returns the index of the condition-code slot to be written. In paired-single mode it returns two results for two adjacent slots. All outputs are registered: each result appears on the clock edge after its inputs are presented.

Top module: `fpcmp_unit`

## Requirements
- R1: Predicate bit 0 accepts unordered, bit 1 accepts equal and bit 2 accepts less-than (operand A below operand B). The result is 1 when any accepted relation holds, otherwise 0. Predicates 0 and 8 are therefore always false.
- R2: Format select 2'b00 compares op_a[31:0] with op_b[31:0] as single precision. 2'b01 compares the full 64-bit buses as double precision. 2'b10 selects paired-single. 2'b11 behaves like 2'b00.
- R3: When abs_mode is 1, the sign bit of each compared value is cleared first: bit 31 for single, bit 63 for double, and bits 31 and 63 of both operands in paired-single.
- R4: In paired-single mode, cond_flag[0] is the result of the low 32-bit lanes and cond_flag[1] the result of the high lanes. cond_pair is 1, cc_lo equals cc_sel and cc_hi equals cc_sel+1 modulo 8.
- R5: Outside paired-single mode, cond_pair is 0, cond_flag[1] is 0, cond_flag[0] carries the result and cc_lo equals cc_sel. Bits 63:32 do not affect a single-precision result.
- R6: Positive and negative zero compare equal and neither is less than the other.
- R7: When either operand is a NaN (exponent all ones, fraction nonzero), the operands are unordered and neither equal nor less-than holds.
- R8: invalid_op is 1 when a signalling NaN (fraction MSB 0) appears in any compared lane, or when a quiet NaN appears and predicate bit 3 is 1. Otherwise it is 0.
- R9: Outputs update one clock edge after the inputs. An active-low asynchronous reset drives every output to 0.
- R10: For each lane, at most one of unordered, equal and less-than holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| fmt_sel | input | 2 | Format: 00 single, 01 double, 10 paired-single |
| pred_sel | input | 4 | Predicate index 0..15 |
| abs_mode | input | 1 | Compare magnitudes instead of signed values |
| cc_sel | input | 3 | Condition-code slot index |
| cond_flag | output | 2 | Predicate results (bit 1 only in paired mode) |
| cond_pair | output | 1 | Two slots are written |
| cc_lo | output | 3 | Slot index for cond_flag[0] |
| cc_hi | output | 3 | Slot index for cond_flag[1] |
| invalid_op | output | 1 | Invalid-operation flag |

## Verification
Two functions can coincide in one cycle: the predicate result and the invalid-operation flag. A signalling NaN under a predicate that accepts unordered returns a true condition and raises invalid together. A quiet NaN under a predicate with bit 3 set returns false and still raises invalid. The bench applies each of these cases and compares the whole registered output word, so a wrong result and a wrong flag are both caught in that cycle. Paired-single also puts two lane results in one cycle. The bench judges them with operand halves chosen so the two lanes differ, including a case where magnitude mode flips only the high lane.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    typedef enum logic [1:0] {
        FMT_SGL  = 2'b00,
        FMT_DBL  = 2'b01,
        FMT_PAIR = 2'b10,
        FMT_RSV  = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [1:0] flag;
        logic       pair;
        logic [2:0] cc_lo;
        logic [2:0] cc_hi;
        logic       inv;
    } cmp_out_t;
endpackage

// File: rtl/fpcmp_lane.sv
module fpcmp_lane #(
    parameter int W  = 32,
    parameter int EW = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         abs_mode,
    output logic         rel_eq,
    output logic         rel_lt,
    output logic         rel_un,
    output logic         sig_nan,
    output logic         quiet_nan
);
    localparam int MW = W - 1 - EW;

    logic [W-1:0]  a_m, b_m;
    logic [EW-1:0] exp_a, exp_b;
    logic [MW-1:0] man_a, man_b;
    logic          nan_a, nan_b, snan_a, snan_b, zero_both, mag_lt, mag_eq;

    always_comb begin
        a_m       = abs_mode ? {1'b0, a[W-2:0]} : a;
        b_m       = abs_mode ? {1'b0, b[W-2:0]} : b;
        exp_a     = a_m[W-2 -: EW];
        exp_b     = b_m[W-2 -: EW];
        man_a     = a_m[MW-1:0];
        man_b     = b_m[MW-1:0];
        nan_a     = (&exp_a) && (|man_a);
        nan_b     = (&exp_b) && (|man_b);
        snan_a    = nan_a && !man_a[MW-1];
        snan_b    = nan_b && !man_b[MW-1];
        zero_both = (a_m[W-2:0] == '0) && (b_m[W-2:0] == '0);
        mag_lt    = a_m[W-2:0] < b_m[W-2:0];
        mag_eq    = a_m[W-2:0] == b_m[W-2:0];
        rel_un    = nan_a || nan_b;
        sig_nan   = snan_a || snan_b;
        quiet_nan = (nan_a && !snan_a) || (nan_b && !snan_b);
        rel_eq    = !rel_un && (zero_both || (mag_eq && (a_m[W-1] == b_m[W-1])));
        if (rel_un || zero_both)
            rel_lt = 1'b0;
        else if (a_m[W-1] != b_m[W-1])
            rel_lt = a_m[W-1];
        else if (!a_m[W-1])
            rel_lt = mag_lt;
        else
            rel_lt = !mag_lt && !mag_eq;
    end

    // R10: relations are mutually exclusive
    always_comb begin
        assert_one_relation_R10: assert ($onehot0({rel_eq, rel_lt, rel_un}));
    end
endmodule

// File: rtl/fpcmp_pred.sv
module fpcmp_pred (
    input  logic [3:0] pred,
    input  logic       rel_eq,
    input  logic       rel_lt,
    input  logic       rel_un,
    input  logic       sig_nan,
    input  logic       quiet_nan,
    output logic       hit,
    output logic       inv
);
    always_comb begin
        hit = (pred[0] && rel_un) || (pred[1] && rel_eq) || (pred[2] && rel_lt);
        inv = sig_nan || (pred[3] && quiet_nan);
    end
endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
    import fpcmp_pkg::*;
#(
    parameter int DW    = 64,
    parameter int CCW   = 3,
    parameter int SW    = DW / 2,
    parameter int S_EXP = 8,
    parameter int D_EXP = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  op_a,
    input  logic [DW-1:0]  op_b,
    input  logic [1:0]     fmt_sel,
    input  logic [3:0]     pred_sel,
    input  logic           abs_mode,
    input  logic [CCW-1:0] cc_sel,
    output logic [1:0]     cond_flag,
    output logic           cond_pair,
    output logic [CCW-1:0] cc_lo,
    output logic [CCW-1:0] cc_hi,
    output logic           invalid_op
);
    localparam int LANES = DW / SW;

    logic [LANES-1:0] s_hit, s_inv;
    logic             d_hit, d_inv;
    cmp_out_t         out_d, out_q;

    for (genvar g = 0; g < LANES; g++) begin : g_sgl
        logic eq, lt, un, sn, qn;
        fpcmp_lane #(.W(SW), .EW(S_EXP)) i_lane (
            .a(op_a[g*SW +: SW]), .b(op_b[g*SW +: SW]), .abs_mode(abs_mode),
            .rel_eq(eq), .rel_lt(lt), .rel_un(un), .sig_nan(sn), .quiet_nan(qn)
        );
        fpcmp_pred i_pred (
            .pred(pred_sel), .rel_eq(eq), .rel_lt(lt), .rel_un(un),
            .sig_nan(sn), .quiet_nan(qn), .hit(s_hit[g]), .inv(s_inv[g])
        );
    end

    logic d_eq, d_lt, d_un, d_sn, d_qn;
    fpcmp_lane #(.W(DW), .EW(D_EXP)) i_dlane (
        .a(op_a), .b(op_b), .abs_mode(abs_mode),
        .rel_eq(d_eq), .rel_lt(d_lt), .rel_un(d_un), .sig_nan(d_sn), .quiet_nan(d_qn)
    );
    fpcmp_pred i_dpred (
        .pred(pred_sel), .rel_eq(d_eq), .rel_lt(d_lt), .rel_un(d_un),
        .sig_nan(d_sn), .quiet_nan(d_qn), .hit(d_hit), .inv(d_inv)
    );

    always_comb begin
        out_d       = '0;
        out_d.cc_lo = cc_sel;
        out_d.cc_hi = cc_sel + 1'b1;
        case (fmt_e'(fmt_sel))
            FMT_DBL: begin
                out_d.flag = {1'b0, d_hit};
                out_d.inv  = d_inv;
            end
            FMT_PAIR: begin
                out_d.flag = {s_hit[1], s_hit[0]};
                out_d.pair = 1'b1;
                out_d.inv  = s_inv[0] || s_inv[1];
            end
            default: begin
                out_d.flag = {1'b0, s_hit[0]};
                out_d.inv  = s_inv[0];
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign cond_flag  = out_q.flag;
    assign cond_pair  = out_q.pair;
    assign cc_lo      = out_q.cc_lo;
    assign cc_hi      = out_q.cc_hi;
    assign invalid_op = out_q.inv;

    assert_pred_false_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pred_sel[2:0]) == 3'b000) |-> (cond_flag == 2'b00));
    assert_pair_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cond_pair |-> ($past(fmt_sel) == FMT_PAIR));
    assert_cc_adjacent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cond_pair |-> (cc_hi == cc_lo + 1'b1));
    assert_hi_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pair |-> !cond_flag[1]);
endmodule

// File: tb/test_fpcmp_unit.sv
module test_fpcmp_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [1:0]  fmt_sel = '0;
    logic [3:0]  pred_sel = '0;
    logic        abs_mode = 0;
    logic [2:0]  cc_sel = '0;
    logic [1:0]  cond_flag;
    logic        cond_pair, invalid_op;
    logic [2:0]  cc_lo, cc_hi;
    int          checks = 0, failures = 0;

    localparam logic [31:0] S1 = 32'h3F800000, S2 = 32'h40000000;
    localparam logic [31:0] SN1 = 32'hBF800000, SN2 = 32'hC0000000;
    localparam logic [31:0] SPZ = 32'h00000000, SNZ = 32'h80000000;
    localparam logic [31:0] SQN = 32'h7FC00000, SSN = 32'h7F800001;
    localparam logic [63:0] D1 = 64'h3FF0000000000000, D2 = 64'h4000000000000000;
    localparam logic [63:0] DN3 = 64'hC008000000000000;
    localparam logic [63:0] DQN = 64'h7FF8000000000000, DSN = 64'h7FF0000000000001;

    always #4 clk = ~clk;

    fpcmp_unit i_fpcmp_unit (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .fmt_sel(fmt_sel),
        .pred_sel(pred_sel), .abs_mode(abs_mode), .cc_sel(cc_sel),
        .cond_flag(cond_flag), .cond_pair(cond_pair), .cc_lo(cc_lo),
        .cc_hi(cc_hi), .invalid_op(invalid_op)
    );

    task automatic check(input string req, input logic [9:0] exp_v);
        logic [9:0] act;
        act = {invalid_op, cond_pair, cc_hi, cc_lo, cond_flag};
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp_v);
        end
    endtask

    function automatic logic [9:0] ev(logic inv, logic pr, logic [2:0] c, logic [1:0] f);
        return {inv, pr, c + 3'd1, c, f};
    endfunction

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] fm,
                         input logic [3:0] p, input logic ab, input logic [2:0] c);
        @(negedge clk);
        op_a = a; op_b = b; fmt_sel = fm; pred_sel = p; abs_mode = ab; cc_sel = c;
        @(negedge clk);
    endtask

    task automatic t_reset;
        check("R9 reset", 10'b0);
    endtask

    task automatic t_single;
        apply({32'hDEADBEEF, S1}, {32'h0, S2}, 2'b00, 4'd4, 0, 3'd2);
        check("R1 R5 olt 1<2", ev(0, 0, 3'd2, 2'b01));
        apply({32'h0, S2}, {32'hFFFFFFFF, S1}, 2'b00, 4'd4, 0, 3'd5);
        check("R1 R2 olt 2<1", ev(0, 0, 3'd5, 2'b00));
        apply({32'h0, SN2}, {32'h0, SN1}, 2'b11, 4'd4, 0, 3'd0);
        check("R2 olt -2<-1 reserved fmt", ev(0, 0, 3'd0, 2'b01));
        apply({32'h0, S1}, {32'h0, S1}, 2'b00, 4'd0, 0, 3'd1);
        check("R1 predicate f false", ev(0, 0, 3'd1, 2'b00));
    endtask

    task automatic t_abs;
        apply({32'h0, SN2}, {32'h0, S1}, 2'b00, 4'd4, 1, 3'd0);
        check("R3 abs |-2|<1 false", ev(0, 0, 3'd0, 2'b00));
        apply({32'h0, SN1}, {32'h0, S1}, 2'b00, 4'd2, 1, 3'd0);
        check("R3 abs eq |-1|=1", ev(0, 0, 3'd0, 2'b01));
    endtask

    task automatic t_double;
        apply(D1, D1, 2'b01, 4'd6, 0, 3'd3);
        check("R2 double ole 1<=1", ev(0, 0, 3'd3, 2'b01));
        apply(DN3, D2, 2'b01, 4'd4, 0, 3'd3);
        check("R2 double olt -3<2", ev(0, 0, 3'd3, 2'b01));
        apply(DN3, D2, 2'b01, 4'd4, 1, 3'd3);
        check("R3 double abs 3<2 false", ev(0, 0, 3'd3, 2'b00));
    endtask

    task automatic t_zero;
        apply({32'h0, SPZ}, {32'h0, SNZ}, 2'b00, 4'd2, 0, 3'd0);
        check("R6 +0 eq -0", ev(0, 0, 3'd0, 2'b01));
        apply({32'h0, SNZ}, {32'h0, SPZ}, 2'b00, 4'd4, 0, 3'd0);
        check("R6 -0 lt +0 false", ev(0, 0, 3'd0, 2'b00));
    endtask

    task automatic t_nan;
        apply({32'h0, SQN}, {32'h0, S1}, 2'b00, 4'd1, 0, 3'd0);
        check("R7 R8 qnan un", ev(0, 0, 3'd0, 2'b01));
        apply({32'h0, SQN}, {32'h0, SQN}, 2'b00, 4'd6, 0, 3'd0);
        check("R7 qnan ole false", ev(0, 0, 3'd0, 2'b00));
        apply({32'h0, S1}, {32'h0, SQN}, 2'b00, 4'd12, 0, 3'd0);
        check("R8 qnan lt invalid", ev(1, 0, 3'd0, 2'b00));
        apply({32'h0, SSN}, {32'h0, S1}, 2'b00, 4'd1, 0, 3'd0);
        check("R8 snan un invalid+true", ev(1, 0, 3'd0, 2'b01));
        apply(DQN, D1, 2'b01, 4'd9, 0, 3'd0);
        check("R8 double qnan ngle", ev(1, 0, 3'd0, 2'b01));
        apply(DSN, D1, 2'b01, 4'd2, 0, 3'd0);
        check("R8 double snan eq", ev(1, 0, 3'd0, 2'b00));
    endtask

    task automatic t_paired;
        apply({SN2, S1}, {S1, S2}, 2'b10, 4'd4, 0, 3'd3);
        check("R4 paired olt", ev(0, 1, 3'd3, 2'b11));
        apply({SN2, S1}, {S1, S2}, 2'b10, 4'd4, 1, 3'd7);
        check("R3 R4 paired abs wrap", ev(0, 1, 3'd7, 2'b01));
        apply({S1, S1}, {SSN, S2}, 2'b10, 4'd4, 0, 3'd0);
        check("R8 paired high snan", ev(1, 1, 3'd0, 2'b01));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_single();
        t_abs();
        t_double();
        t_zero();
        t_nan();
        t_paired();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule